// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Interrupt Point

This block sends bytes as asynchronous serial frames. A byte is written into a one-entry holding register. As soon as the shift stage is free, the byte moves into a shift register and goes out on a single output line.

Each frame has the following parts, in order:
- a low start bit;
- the data bits, least significant first;
- an optional ninth (expansion) bit;
- an optional parity bit;
- one or two high stop bits.

A byte written while a frame is still being sent waits in the holding register. It starts directly after the current stop bits, so consecutive frames have no idle gap between them.

Bit timing comes from a power-of-two prescaler followed by an integer divider. Both counters restart whenever a frame is loaded, so bit edges line up with the load. A busy flag covers the whole time from the write to the last stop bit. One interrupt output gives a single-cycle pulse. A configuration input chooses when it fires: at the hand-off from the holding register to the shift register, or after the final stop bit.

Top module: `serial_tx`

## Requirements
- R1: After reset, `txOut` is 1, `busy` is 0 and `txIrq` is 0.
- R2: A write (`wrEn` high at a clock edge) sets `busy` from the next cycle. The start bit appears on `txOut` one cycle after that.
- R3: A frame is sent in this order: start bit 0, then `wrData` LSB first, then the expansion bit (if enabled), then the parity bit (if enabled), then the stop bits at 1.
- R4: Every bit lasts exactly 2^`presSel` × max(`divisor`,1) clock cycles. A divisor of 0 behaves as 1.
- R5: The `parMode` encodings are:
  - 00: no parity bit.
  - 01: parity bit forced to 0.
  - 10: odd parity; the count of ones over the data, the enabled expansion bit and the parity bit is odd.
  - 11: even parity; that same count is even.
- R6: `twoStop` = 1 sends two stop bits; 0 sends one.
- R7: With `irqAtEnd` = 0, `txIrq` pulses for one cycle. The pulse comes in the cycle in which the start bit of a loaded frame first appears.
- R8: With `irqAtEnd` = 1, `txIrq` pulses for one cycle. The pulse comes in the first cycle after the final stop bit, which is the same cycle in which `busy` falls when no byte is waiting.
- R9: At the end of a frame, `busy` clears only if no further byte is waiting. While a byte is pending it stays at 1.
- R10: A byte written during a frame begins its start bit in the cycle right after the last stop bit of that frame.
- R11: With `expEn` = 0, no expansion bit is sent and `expBit` has no effect on parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Byte to transmit |
| expEn | input | 1 | Enables the expansion bit |
| expBit | input | 1 | Value of the expansion bit |
| parMode | input | 2 | Parity mode (see R5) |
| twoStop | input | 1 | Selects two stop bits |
| irqAtEnd | input | 1 | Interrupt point: 0 at load, 1 at frame end |
| presSel | input | PRE_W | Prescaler exponent |
| divisor | input | DIV_W | Prescaled ticks per bit |
| txOut | output | 1 | Serial output, idles high |
| busy | output | 1 | Transmission in progress or pending |
| txIrq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench uses the defaults DATA_W = 8, PRE_W = 2 and DIV_W = 8. It runs three bit periods:
- 1 cycle (presSel 0, divisor 1), where each bit lasts a single cycle and any off-by-one in the counter restart shows up at once;
- 6 cycles (presSel 1, divisor 3), which exercises both counter stages together;
- 4 cycles (presSel 2, divisor 0), which covers the zero-divisor corner.

Every cycle of every frame is compared with the expected line level. This covers the longest frame of 13 bits and the no-gap hand-off between back-to-back frames in both interrupt modes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } parMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // copy frame from holding register into shifter
    logic shift;    // advance to next bit
    logic idleFill; // frame finished, nothing waiting
  } txStrobe_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [PRE_W-1:0] presSel,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitTick
);
  localparam int PC_W = 2 ** PRE_W;

  logic [PC_W-1:0]  presCnt;
  logic [PC_W-1:0]  presMax;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             presTick;

  always_comb begin
    presMax  = {PC_W{1'b1}} >> (PC_W - int'(presSel));
    divLast  = (divisor == '0) ? '0 : divisor - 1'b1;
    presTick = (presCnt == presMax);
    bitTick  = presTick && (divCnt == divLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
      divCnt  <= '0;
    end else if (restart) begin
      presCnt <= '0;
      divCnt  <= '0;
    end else if (presTick) begin
      presCnt <= '0;
      divCnt  <= (divCnt == divLast) ? '0 : divCnt + 1'b1;
    end else begin
      presCnt <= presCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             holdValid,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             irqAtEnd,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             txIrq
);
  typedef enum logic {ST_IDLE, ST_SEND} state_e;

  state_e           state;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  always_comb begin
    lastBit         = (state == ST_SEND) && bitTick && (bitCnt == frameLen - 1'b1);
    strobe.load     = ((state == ST_IDLE) || lastBit) && holdValid;
    strobe.shift    = (state == ST_SEND) && bitTick && !lastBit;
    strobe.idleFill = lastBit && !holdValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      busy   <= 1'b0;
      txIrq  <= 1'b0;
    end else begin
      if (strobe.load) begin
        state  <= ST_SEND;
        bitCnt <= '0;
      end else if (strobe.idleFill) begin
        state  <= ST_IDLE;
      end else if (strobe.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (wrEn)                 busy <= 1'b1;
      else if (strobe.idleFill) busy <= 1'b0;

      txIrq <= irqAtEnd ? lastBit : strobe.load;
    end
  end
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FR_W   = DATA_W + 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expEn,
  input  logic              expBit,
  input  logic [1:0]        parMode,
  input  logic              twoStop,
  input  txStrobe_t         strobe,
  output logic              holdValid,
  output logic [CNT_W-1:0]  frameLen,
  output logic              txOut
);
  logic [DATA_W-1:0] holdData;
  logic [FR_W-1:0]   shReg;
  logic [FR_W-1:0]   frameNext;
  logic [CNT_W-1:0]  lenNext;
  logic              parBit;
  logic              onesOdd;
  parMode_e          pm;

  always_comb begin
    int idx;
    pm        = parMode_e'(parMode);
    onesOdd   = (^holdData) ^ (expEn & expBit);
    unique case (pm)
      PAR_ODD:  parBit = ~onesOdd;
      PAR_EVEN: parBit = onesOdd;
      default:  parBit = 1'b0;
    endcase
    frameNext = '1;
    frameNext[0] = 1'b0;
    frameNext[DATA_W:1] = holdData;
    idx = DATA_W + 1;
    if (expEn) begin
      frameNext[idx] = expBit;
      idx++;
    end
    if (pm != PAR_NONE) begin
      frameNext[idx] = parBit;
      idx++;
    end
    lenNext = CNT_W'(idx + 1 + int'(twoStop));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData  <= '0;
      holdValid <= 1'b0;
      shReg     <= '1;
      frameLen  <= '0;
    end else begin
      if (wrEn) begin
        holdData  <= wrData;
        holdValid <= 1'b1;
      end else if (strobe.load) begin
        holdValid <= 1'b0;
      end

      if (strobe.load) begin
        shReg    <= frameNext;
        frameLen <= lenNext;
      end else if (strobe.shift) begin
        shReg <= {1'b1, shReg[FR_W-1:1]};
      end else if (strobe.idleFill) begin
        shReg <= '1;
      end
    end
  end

  assign txOut = shReg[0];
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expEn,
  input  logic              expBit,
  input  logic [1:0]        parMode,
  input  logic              twoStop,
  input  logic              irqAtEnd,
  input  logic [PRE_W-1:0]  presSel,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txOut,
  output logic              busy,
  output logic              txIrq
);
  localparam int FR_W  = DATA_W + 5;
  localparam int CNT_W = $clog2(FR_W + 1);

  txStrobe_t        strobe;
  logic             holdValid;
  logic             bitTick;
  logic [CNT_W-1:0] frameLen;

  sertx_baud #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .restart(strobe.load),
    .presSel(presSel), .divisor(divisor), .bitTick(bitTick)
  );

  sertx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .holdValid(holdValid),
    .bitTick(bitTick), .frameLen(frameLen), .irqAtEnd(irqAtEnd),
    .strobe(strobe), .busy(busy), .txIrq(txIrq)
  );

  sertx_dp #(.DATA_W(DATA_W), .FR_W(FR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .expEn(expEn), .expBit(expBit), .parMode(parMode), .twoStop(twoStop),
    .strobe(strobe), .holdValid(holdValid), .frameLen(frameLen), .txOut(txOut)
  );
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic irqAtEnd,
  input logic txOut,
  input logic busy,
  input logic txIrq
);
  // R2
  write_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> busy);

  // R9
  low_line_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txOut |-> busy);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R7
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  // R8
  end_irq_with_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && irqAtEnd) |-> txIrq);
endmodule

bind serial_tx serial_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .irqAtEnd(irqAtEnd),
  .txOut(txOut), .busy(busy), .txIrq(txIrq)
);

// File: tb/serial_tx_bench.sv
`timescale 1ns/1ps
module serial_tx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       expEn = 1'b0, expBit = 1'b0, twoStop = 1'b0, irqAtEnd = 1'b0;
  logic [1:0] parMode = 2'b00;
  logic [1:0] presSel = 2'd0;
  logic [7:0] divisor = 8'd1;
  logic       txOut, busy, txIrq;
  int         nVec = 0, nBad = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  serial_tx u_serial_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .expEn(expEn), .expBit(expBit), .parMode(parMode), .twoStop(twoStop),
    .irqAtEnd(irqAtEnd), .presSel(presSel), .divisor(divisor),
    .txOut(txOut), .busy(busy), .txIrq(txIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic buildFrame(input logic [7:0] d, output logic [15:0] bits, output int len);
    int idx;
    int ones;
    logic par;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    idx = 9;
    ones = $countones(d) + ((expEn && expBit) ? 1 : 0);
    if (expEn) begin
      bits[idx] = expBit;
      idx++;
    end
    case (parMode)
      2'b01:   par = 1'b0;
      2'b10:   par = (ones % 2 == 0);
      default: par = (ones % 2 == 1);
    endcase
    if (parMode != 2'b00) begin
      bits[idx] = par;
      idx++;
    end
    len = idx + 1 + (twoStop ? 1 : 0);
  endtask

  // sends d1 (and d2 back to back when second=1), checks every cycle
  task automatic runFrames(input string name, input logic [7:0] d1,
                           input bit second, input logic [7:0] d2);
    logic [15:0] b1, b2;
    int len, l2, per, total, k, f, expIrq, expBit0;
    per = (1 << presSel) * ((divisor == 0) ? 1 : int'(divisor));
    buildFrame(d1, b1, len);
    buildFrame(d2, b2, l2);
    total = (second ? 2 : 1) * len * per;
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    chk({name, " R2 busy after write"}, busy, 1);
    chk({name, " R2 line idle before start"}, txOut, 1);
    for (int c = 0; c <= total + 1; c++) begin
      @(negedge clk);
      if (c < total) begin
        k = c / per;
        expBit0 = (k < len) ? b1[k] : b2[k - len];
        chk({name, " R3 R4 R5 R6 R11 line level"}, txOut, expBit0);
        chk({name, " R9 busy during frame"}, busy, 1);
      end else begin
        chk({name, " R1 line idle after frame"}, txOut, 1);
        chk({name, " R9 busy cleared"}, busy, 0);
      end
      expIrq = 0;
      for (f = 0; f < (second ? 2 : 1); f++) begin
        if (!irqAtEnd && c == f * len * per) expIrq = 1;
        if (irqAtEnd && c == (f + 1) * len * per) expIrq = 1;
      end
      chk({name, irqAtEnd ? " R8 irq at end" : " R7 irq at load"}, txIrq, expIrq);
      if (second && c == 2 * per) begin
        wrEn = 1'b1;
        wrData = d2;
      end else begin
        wrEn = 1'b0;
      end
    end
  endtask

  task automatic tReset();
    chk("R1 txOut reset", txOut, 1);
    chk("R1 busy reset", busy, 0);
    chk("R1 irq reset", txIrq, 0);
  endtask

  task automatic tBasic();
    presSel = 0; divisor = 1; parMode = 2'b00; expEn = 0; twoStop = 0; irqAtEnd = 0;
    runFrames("basic8N1", 8'hA5, 0, 8'h00);
  endtask

  task automatic tParity();
    presSel = 1; divisor = 3; expEn = 0; expBit = 1; twoStop = 0; irqAtEnd = 1;
    parMode = 2'b11; runFrames("even R5 R11", 8'h13, 0, 8'h00);
    parMode = 2'b10; runFrames("odd R5", 8'h13, 0, 8'h00);
    parMode = 2'b01; runFrames("zero R5", 8'hFF, 0, 8'h00);
  endtask

  task automatic tExpansion();
    presSel = 1; divisor = 3; expEn = 1; expBit = 1; parMode = 2'b11;
    twoStop = 1; irqAtEnd = 1;
    runFrames("exp9 even 2stop R6", 8'h01, 0, 8'h00);
    expBit = 0; parMode = 2'b10; irqAtEnd = 0;
    runFrames("exp9 odd R3", 8'h80, 0, 8'h00);
  endtask

  task automatic tBackToBack();
    presSel = 0; divisor = 1; expEn = 0; parMode = 2'b00; twoStop = 0; irqAtEnd = 0;
    runFrames("b2b load R10", 8'h3C, 1, 8'hC3);
    presSel = 2; divisor = 0; twoStop = 1; irqAtEnd = 1;
    runFrames("b2b end div0 R10 R4", 8'h55, 1, 8'h0F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tBasic();
    tParity();
    tExpansion();
    tBackToBack();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule